// File: doc/BRIEF.md
# Pin I/O Controller with Edge Interrupts

This block lets software own up to 32 general-purpose pins through a small word-addressed register bus. Each pin is described by a four-bit control field. Software writes the field to choose whether the pin is driven and which level it drives. The same field reads back the level actually present on the pad. Eight fields pack into one 32-bit control word, so four control words cover all the pins.

The lower sixteen pins can also report level changes. Every pad input first passes through a two-flop synchroniser. Edges are then detected on the synchronised value. A rising edge on pin n sets status bit n, and a falling edge sets status bit n+16. Status bits stay set until software clears them by writing ones. A matching enable register selects which status bits reach the single interrupt output.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every control field reads with bit 1 set and bit 0 clear, `pad_oe_o` and `pad_out_o` are all zero, the enable and status registers read zero, and `irq_o` is low.
- R2: Word address 0 to 3 holds the control fields of pins 8a to 8a+7. Pin n's field sits at bits 4(n mod 8)+3 down to 4(n mod 8) of word n/8.
- R3: In a control field, bit 0 is the drive level and appears on `pad_out_o[n]`. Bit 1 set makes the pin an input (`pad_oe_o[n]` low), and bit 1 clear drives it (`pad_oe_o[n]` high). Bit 3 always reads 0. A control write replaces bits 0 and 1 of all eight fields of the addressed word on the next clock edge.
- R4: Bit 2 of a control field is read-only and returns the pad level after a two-flop synchroniser. A pad change set up before clock edge k is visible in the readback after edge k+1 and not after edge k.
- R5: Word addresses 6 and 7 read as zero, and writes to them change no register or pin output.
- R6: Status lives at word address 5. Bits 15:0 latch rising edges of pins 0 to 15, and bits 31:16 latch falling edges of the same pins. Pins 16 to 31 never set any status bit.
- R7: The enable register at word address 4 uses the status layout (rise in 15:0, fall in 31:16). It is fully writable and reads back what was written.
- R8: Writing to address 5 clears every status bit written with 1 and leaves every bit written with 0 unchanged.
- R9: `irq_o` is high exactly when some bit is set in both status and enable. Status bits latch edges whatever their enable bits hold.
- R10: When an edge and a clearing write hit the same status bit in the same cycle, the bit ends that cycle set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pad_in_i | input | 32 | Levels seen at the pads |
| pad_out_o | output | 32 | Drive level per pin |
| pad_oe_o | output | 32 | Output enable per pin, high when driven |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that reset is applied while the pad inputs are low. The synchroniser and edge history reset to zero, so a pad already high at reset release would register as a genuine rising edge. They also assume that bus signals change only between clock edges. The bench holds every pad low during reset and drives pads and bus signals on the falling clock edge. After each pad change it waits enough cycles for the synchroniser and edge latch to settle before reading status. The one exception is the collision test, which aims a clearing write at the exact cycle in which a detected edge is latched.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int REG_W        = 32;
    localparam int NIB_W        = 4;
    localparam int PINS_PER_REG = REG_W / NIB_W;
    localparam int NIB_OUT      = 0;
    localparam int NIB_DIR      = 1;

    function automatic logic [NIB_W-1:0] make_nibble(input logic sense,
                                                     input logic in_mode,
                                                     input logic level);
        return {1'b0, sense, in_mode, level};
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.stable;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_t;

    edge_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = sync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = sync_i & ~s_q.prev;
    assign fall_o = ~sync_i & s_q.prev;

    // R6
    quiet_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sync_i) |-> ((rise_o | fall_o) == '0))
        else $error("edge reported on a steady input");
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int IRQ_PINS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IRQ_PINS-1:0]   rise_i,
    input  logic [IRQ_PINS-1:0]   fall_i,
    input  logic                  en_wr_i,
    input  logic                  st_wr_i,
    input  logic [2*IRQ_PINS-1:0] wdata_i,
    output logic [2*IRQ_PINS-1:0] enable_o,
    output logic [2*IRQ_PINS-1:0] status_o,
    output logic                  irq_o
);
    localparam int EV_W = 2 * IRQ_PINS;

    typedef struct packed {
        logic [EV_W-1:0] en;
        logic [EV_W-1:0] st;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic [EV_W-1:0] evt;
    logic [EV_W-1:0] clr_mask;

    assign evt      = {fall_i, rise_i};
    assign clr_mask = st_wr_i ? wdata_i : '0;

    always_comb begin
        s_d = s_q;
        if (en_wr_i) begin
            s_d.en = wdata_i;
        end
        s_d.st = (s_q.st & ~clr_mask) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign enable_o = s_q.en;
    assign status_o = s_q.st;
    assign irq_o    = |(s_q.st & s_q.en);

    // R10
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & clr_mask) != '0) |=> ((s_q.st & $past(evt & clr_mask)) == $past(evt & clr_mask)))
        else $error("clear overrode a same-cycle edge");

    // R8
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.st & $past(s_q.st & ~clr_mask)) == $past(s_q.st & ~clr_mask)))
        else $error("status bit dropped without a clearing write");

    // R9
    status_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.st & ~$past(s_q.st) & ~$past(evt)) == '0))
        else $error("status bit set without an edge");
endmodule

// File: rtl/gpio_pinctl.sv
module gpio_pinctl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_PINS/PINS_PER_REG-1:0] wr_sel_i,
    input  logic [PINS_PER_REG-1:0] w_out_i,
    input  logic [PINS_PER_REG-1:0] w_dir_i,
    output logic [NUM_PINS-1:0]     level_o,
    output logic [NUM_PINS-1:0]     in_mode_o
);
    localparam int CTRL_REGS = NUM_PINS / PINS_PER_REG;

    typedef struct packed {
        logic [NUM_PINS-1:0] level;
        logic [NUM_PINS-1:0] in_mode;
    } pin_state_t;

    pin_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int r = 0; r < CTRL_REGS; r++) begin
            if (wr_sel_i[r]) begin
                s_d.level[r*PINS_PER_REG +: PINS_PER_REG]   = w_out_i;
                s_d.in_mode[r*PINS_PER_REG +: PINS_PER_REG] = w_dir_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.level   <= '0;
            s_q.in_mode <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o   = s_q.level;
    assign in_mode_o = s_q.in_mode;

    for (genvar r = 0; r < CTRL_REGS; r++) begin : g_word_chk
        // R3
        ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_sel_i[r] |=> (s_q.level[r*PINS_PER_REG +: PINS_PER_REG] == $past(w_out_i)
                          && s_q.in_mode[r*PINS_PER_REG +: PINS_PER_REG] == $past(w_dir_i)))
            else $error("control word %0d did not take the written value", r);
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int IRQ_PINS = 16,
    parameter int ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [REG_W-1:0]    wdata_i,
    output logic [REG_W-1:0]    rdata_o,
    input  logic [NUM_PINS-1:0] pad_in_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic                irq_o
);
    localparam int CTRL_REGS   = NUM_PINS / PINS_PER_REG;
    localparam int ENABLE_ADDR = CTRL_REGS;
    localparam int STATUS_ADDR = CTRL_REGS + 1;

    logic [CTRL_REGS-1:0]    ctrl_wr;
    logic [PINS_PER_REG-1:0] w_out;
    logic [PINS_PER_REG-1:0] w_dir;
    logic                    en_wr;
    logic                    st_wr;
    logic [NUM_PINS-1:0]     sense;
    logic [NUM_PINS-1:0]     level;
    logic [NUM_PINS-1:0]     in_mode;
    logic [IRQ_PINS-1:0]     rise;
    logic [IRQ_PINS-1:0]     fall;
    logic [2*IRQ_PINS-1:0]   enable;
    logic [2*IRQ_PINS-1:0]   status;

    always_comb begin
        for (int r = 0; r < CTRL_REGS; r++) begin
            ctrl_wr[r] = wr_en_i && (addr_i == ADDR_W'(r));
        end
    end

    assign en_wr = wr_en_i && (addr_i == ADDR_W'(ENABLE_ADDR));
    assign st_wr = wr_en_i && (addr_i == ADDR_W'(STATUS_ADDR));

    for (genvar j = 0; j < PINS_PER_REG; j++) begin : g_field
        assign w_out[j] = wdata_i[j*NIB_W + NIB_OUT];
        assign w_dir[j] = wdata_i[j*NIB_W + NIB_DIR];
    end

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in_i),
        .sync_o  (sense)
    );

    gpio_edge #(.W(IRQ_PINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sense[IRQ_PINS-1:0]),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpio_irq #(.IRQ_PINS(IRQ_PINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .fall_i   (fall),
        .en_wr_i  (en_wr),
        .st_wr_i  (st_wr),
        .wdata_i  (wdata_i),
        .enable_o (enable),
        .status_o (status),
        .irq_o    (irq_o)
    );

    gpio_pinctl #(.NUM_PINS(NUM_PINS)) u_pinctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel_i  (ctrl_wr),
        .w_out_i   (w_out),
        .w_dir_i   (w_dir),
        .level_o   (level),
        .in_mode_o (in_mode)
    );

    assign pad_out_o = level;
    assign pad_oe_o  = ~in_mode;

    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < CTRL_REGS; r++) begin
            if (addr_i == ADDR_W'(r)) begin
                for (int j = 0; j < PINS_PER_REG; j++) begin
                    rdata_o[j*NIB_W +: NIB_W] = make_nibble(sense[r*PINS_PER_REG + j],
                                                            in_mode[r*PINS_PER_REG + j],
                                                            level[r*PINS_PER_REG + j]);
                end
            end
        end
        if (addr_i == ADDR_W'(ENABLE_ADDR)) begin
            rdata_o = enable;
        end
        if (addr_i == ADDR_W'(STATUS_ADDR)) begin
            rdata_o = status;
        end
    end

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status != '0))
        else $error("interrupt raised with empty status");

    // R5
    rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i > ADDR_W'(STATUS_ADDR))
            |=> ($stable(pad_out_o) && $stable(pad_oe_o) && $stable(enable)))
        else $error("reserved write changed state");

    // R3
    idle_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(pad_out_o) && $stable(pad_oe_o)))
        else $error("pin outputs moved without a write");
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
`timescale 1ns/100ps
module gpio_edge_ctrl_tb;
    localparam int NV = 41;
    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_PAD = 3'd2,
                           OP_IRQ = 3'd3, OP_OE = 3'd4, OP_OUT = 3'd5;

    function automatic logic [73:0] mk(input logic [2:0] op, input logic [2:0] a,
                                       input logic [31:0] d, input logic [31:0] e,
                                       input logic [3:0] rq);
        return {op, a, d, e, rq};
    endfunction

    localparam logic [73:0] VEC [NV] = '{
        mk(OP_RD,  3'd0, 32'h0,        32'h22222222, 4'd1),  // R1
        mk(OP_RD,  3'd4, 32'h0,        32'h00000000, 4'd1),  // R1
        mk(OP_RD,  3'd5, 32'h0,        32'h00000000, 4'd1),  // R1
        mk(OP_OE,  3'd0, 32'h0,        32'h00000000, 4'd1),  // R1
        mk(OP_IRQ, 3'd0, 32'h0,        32'h00000000, 4'd1),  // R1
        mk(OP_WR,  3'd0, 32'h00000031, 32'h0,        4'd2),
        mk(OP_RD,  3'd0, 32'h0,        32'h00000031, 4'd2),  // R2
        mk(OP_WR,  3'd1, 32'hFFFFFFFF, 32'h0,        4'd3),
        mk(OP_RD,  3'd1, 32'h0,        32'h33333333, 4'd3),  // R3
        mk(OP_OE,  3'd0, 32'h0,        32'h000000FD, 4'd3),  // R3
        mk(OP_OUT, 3'd0, 32'h0,        32'h0000FF03, 4'd3),  // R3
        mk(OP_PAD, 3'd0, 32'h00000100, 32'h0,        4'd4),
        mk(OP_RD,  3'd1, 32'h0,        32'h33333337, 4'd4),  // R4
        mk(OP_RD,  3'd5, 32'h0,        32'h00000100, 4'd6),  // R6
        mk(OP_IRQ, 3'd0, 32'h0,        32'h00000000, 4'd9),  // R9
        mk(OP_PAD, 3'd0, 32'h00000000, 32'h0,        4'd6),
        mk(OP_RD,  3'd5, 32'h0,        32'h01000100, 4'd6),  // R6
        mk(OP_WR,  3'd5, 32'h00000100, 32'h0,        4'd8),
        mk(OP_RD,  3'd5, 32'h0,        32'h01000000, 4'd8),  // R8
        mk(OP_WR,  3'd4, 32'h01000000, 32'h0,        4'd7),
        mk(OP_RD,  3'd4, 32'h0,        32'h01000000, 4'd7),  // R7
        mk(OP_IRQ, 3'd0, 32'h0,        32'h00000001, 4'd9),  // R9
        mk(OP_WR,  3'd5, 32'h01000000, 32'h0,        4'd8),
        mk(OP_RD,  3'd5, 32'h0,        32'h00000000, 4'd8),  // R8
        mk(OP_IRQ, 3'd0, 32'h0,        32'h00000000, 4'd9),  // R9
        mk(OP_PAD, 3'd0, 32'h00100000, 32'h0,        4'd4),
        mk(OP_RD,  3'd2, 32'h0,        32'h22262222, 4'd2),  // R2
        mk(OP_RD,  3'd5, 32'h0,        32'h00000000, 4'd6),  // R6
        mk(OP_WR,  3'd6, 32'hFFFFFFFF, 32'h0,        4'd5),
        mk(OP_RD,  3'd6, 32'h0,        32'h00000000, 4'd5),  // R5
        mk(OP_RD,  3'd0, 32'h0,        32'h00000031, 4'd5),  // R5
        mk(OP_RD,  3'd4, 32'h0,        32'h01000000, 4'd5),  // R5
        mk(OP_WR,  3'd4, 32'h00008000, 32'h0,        4'd7),
        mk(OP_PAD, 3'd0, 32'h00108000, 32'h0,        4'd6),
        mk(OP_RD,  3'd5, 32'h0,        32'h00008000, 4'd6),  // R6
        mk(OP_IRQ, 3'd0, 32'h0,        32'h00000001, 4'd9),  // R9
        mk(OP_RD,  3'd7, 32'h0,        32'h00000000, 4'd5),  // R5
        mk(OP_PAD, 3'd0, 32'h00000000, 32'h0,        4'd6),
        mk(OP_RD,  3'd5, 32'h0,        32'h80008000, 4'd6),  // R6
        mk(OP_WR,  3'd5, 32'hFFFFFFFF, 32'h0,        4'd8),
        mk(OP_RD,  3'd5, 32'h0,        32'h00000000, 4'd8)   // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .pad_in_i  (pad_in),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe),
        .irq_o     (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_pads(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [2:0]  a;
            logic [31:0] d, e;
            logic [3:0]  rq;
            string tag;
            {op, a, d, e, rq} = VEC[i];
            tag = $sformatf("R%0d vec%0d", rq, i);
            case (op)
                OP_WR:  bus_write(a, d);
                OP_PAD: set_pads(d);
                OP_RD: begin
                    bus_read(a, rd);
                    check(tag, rd, e);
                end
                OP_IRQ: begin @(negedge clk); check(tag, {31'b0, irq}, e); end
                OP_OE:  begin @(negedge clk); check(tag, pad_oe, e); end
                default: begin @(negedge clk); check(tag, pad_out, e); end
            endcase
        end

        // R4: readback latency through the synchroniser
        @(negedge clk);
        pad_in = 32'h00000001;
        addr = 3'd0;
        @(negedge clk);
        #1 check("R4 sense after one edge", {31'b0, rdata[2]}, 32'h0);
        @(negedge clk);
        #1 check("R4 sense after two edges", {31'b0, rdata[2]}, 32'h1);
        repeat (3) @(negedge clk);

        // R10: clearing write collides with a fresh rise on pin 0
        set_pads(32'h00000000);
        bus_read(3'd5, rd);
        check("R6 rise and fall of pin 0", rd, 32'h00010001);
        @(negedge clk);
        pad_in = 32'h00000001;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd5; wdata = 32'h00010001;
        @(negedge clk);
        wr_en = 1'b0;
        bus_read(3'd5, rd);
        check("R10 edge survives same-cycle clear", rd, 32'h00000001);

        // R1: reset in the middle of operation
        set_pads(32'h00000000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(3'd0, rd);
        check("R1 control after reset", rd, 32'h22222222);
        bus_read(3'd5, rd);
        check("R1 status after reset", rd, 32'h0);
        bus_read(3'd4, rd);
        check("R1 enable after reset", rd, 32'h0);
        check("R1 pad_out after reset", pad_out, 32'h0);
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule